// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a three-wire control link. It lets an external controller read and write a bank of byte-wide configuration registers. The controller frames each access with an active-low chip select and sets the direction with a separate read/write level. It then clocks sixteen bits on a shared serial data line: first an 8-bit register address, then one data byte. On a write the controller drives the data byte. On a read the block takes over the line and returns the register contents.

Registers sit on word-spaced addresses, so register n answers at address 4·n. Register 0 is fixed and returns a version code. The remaining registers hold whatever was last written to them. All sampling happens on the rising edge of the serial clock.

The data line leaves the block as a separate output value and output enable. A pad-level tristate buffer combines them with the input into one wire.

Top module: `serial_cfg_port`

## Requirements
- R1: Each frame starts with 8 address bits, most significant first. Register n (0 to 17) is selected by address 4·n.
- R2: On a write (`rd_wr` = 0), 8 data bits follow the address, most significant first. The assembled byte is stored on the rising edge that captures the 16th bit of the frame.
- R3: On a read (`rd_wr` = 1), the most significant data bit appears on `sd_out` right after the edge that captures the last address bit. Each later rising edge moves `sd_out` to the next lower bit, ending with the least significant bit.
- R4: `sd_oe` is 1 only while chip select is low, `rd_wr` is 1, and the frame is in its 8 data-bit periods. It is 0 at all other times, including after reset and after the 16th edge.
- R5: Register 0 reads as the version code, 0x5C by default. Writes to it have no effect.
- R6: A write to an address that is not a multiple of 4, or that is above 0x44, changes no register. A read of such an address returns 0x00.
- R7: Raising `cs_n` in the middle of a frame abandons it without changing any register, and the next frame starts again at address bit 7.
- R8: After reset, registers 1 to 17 read as 0x00.
- R9: Rising edges after the 16th bit of a frame are ignored until `cs_n` goes high: no register changes and `sd_oe` stays 0.
- R10: A read frame never changes any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; all sampling on its rising edge |
| cs_n | input | 1 | Active-low chip select framing each transaction |
| rd_wr | input | 1 | Direction level: 1 = read, 0 = write |
| sd_in | input | 1 | Serial data arriving from the shared line |
| sd_out | output | 1 | Serial read data driven toward the shared line |
| sd_oe | output | 1 | Output enable for the shared line's tristate driver |

## Verification
The bench aims at the edge where the bus turns around. A design that loads the read byte one edge late would send every bit shifted by one position. One that enables the driver a cycle early would fight the controller on the last address bit.

It also writes to register 0, to misaligned addresses and to addresses past 0x44, then reads back neighbouring registers. An off-by-one decode would corrupt the wrong register or return stale data instead of zero.

Frames cut short by chip select, and frames overrun with extra clocks, would expose a counter that keeps its count across frames, or one that wraps around and commits a second byte.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NREG = 18,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int STRIDE_LOG2 = 2,
  parameter logic [DW-1:0] VERSION = 8'h5C
) (
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic rd_wr,
  input  logic sd_in,
  output logic sd_out,
  output logic sd_oe
);
  localparam int FRAME = AW + DW;
  localparam int CW = $clog2(FRAME + 1);
  localparam int IW = AW - STRIDE_LOG2;
  localparam logic [CW-1:0] C_ADDR_LAST  = CW'(AW - 1);
  localparam logic [CW-1:0] C_DATA_FIRST = CW'(AW);
  localparam logic [CW-1:0] C_LAST       = CW'(FRAME - 1);
  localparam logic [CW-1:0] C_DONE       = CW'(FRAME);

  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wsh, tsh, rd_byte;
  logic [NREG-1:1][DW-1:0] regs;

  wire [AW-1:0] addr_nx = {addr_q[AW-2:0], sd_in};
  wire [DW-1:0] wbyte   = {wsh[DW-2:0], sd_in};
  wire [IW-1:0] ridx    = addr_nx[AW-1:STRIDE_LOG2];
  wire [IW-1:0] widx    = addr_q[AW-1:STRIDE_LOG2];
  wire ralign = (addr_nx[STRIDE_LOG2-1:0] == '0) && (ridx < IW'(NREG));
  wire wr_ok  = (addr_q[STRIDE_LOG2-1:0] == '0) && (widx < IW'(NREG)) && (widx != '0);
  wire commit = !cs_n && !rd_wr && (cnt == C_LAST);

  always_comb begin
    rd_byte = '0;
    if (ralign) begin
      if (ridx == '0) rd_byte = VERSION;
      for (int i = 1; i < NREG; i++)
        if (ridx == IW'(i)) rd_byte = regs[i];
    end
  end

  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cs_n)          cnt <= '0;
    else if (cnt != C_DONE) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wsh    <= '0;
      tsh    <= '0;
    end else if (!cs_n) begin
      if (cnt < C_DATA_FIRST) addr_q <= addr_nx;
      if (cnt == C_ADDR_LAST) begin
        tsh <= rd_byte;
      end else if (cnt >= C_DATA_FIRST && cnt <= C_LAST) begin
        tsh <= {tsh[DW-2:0], 1'b0};
        wsh <= wbyte;
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) regs <= '0;
    else if (commit && wr_ok)
      for (int i = 1; i < NREG; i++)
        if (widx == IW'(i)) regs[i] <= wbyte;
  end

  assign sd_oe  = !cs_n && rd_wr && (cnt >= C_DATA_FIRST) && (cnt <= C_LAST);
  assign sd_out = tsh[DW-1];

  p_cnt_step_r1: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    ($past(cnt) != C_DONE && !$past(cs_n)) |-> cnt == $past(cnt) + 1'b1);

  p_no_early_write_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    (cnt != C_LAST) |=> $stable(regs));

  p_read_no_write_r10: assert property (@(posedge sclk) disable iff (!rst_n)
    (rd_wr && !cs_n) |=> $stable(regs));

  p_bad_addr_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    (cnt == C_LAST && !wr_ok) |=> $stable(regs));

  p_hold_after_frame_r9: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (cnt == C_DONE) |=> (cnt == C_DONE && !sd_oe));
endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
  localparam int P = 10;
  localparam int NR = 18;
  localparam logic [7:0] VER = 8'h5C;

  logic rst_n = 0, sclk = 0, cs_n = 1, rd_wr = 0, sd_in = 0;
  logic sd_out, sd_oe;
  int checks = 0, fails = 0;
  int model [NR];
  logic done = 0;

  serial_cfg_port u_dut (.rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .rd_wr(rd_wr),
                         .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe));

  always #(P/2) sclk = ~sclk;

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a[1:0] != 0 || a / 4 >= NR) return 8'h00;
    if (a == 0) return VER;
    return model[a/4][7:0];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge sclk); #(P/4);
      chk(tag, {7'd0, sd_oe}, 8'd0);
    end
  endtask

  // one frame; nbits < 16 aborts, extra > 0 overruns
  task automatic xfer(input logic rd, input logic [7:0] a, input logic [7:0] d,
                      input int nbits, input int extra, input string tag);
    logic [7:0] exp;
    exp = mread(a);
    for (int e = 1; e <= nbits + extra; e++) begin
      @(negedge sclk);
      cs_n = 0; rd_wr = rd;
      if (e <= 8)       sd_in = a[8-e];
      else if (e <= 16) sd_in = d[16-e];
      else              sd_in = e[0];
      @(posedge sclk); #(P/4);
      if (rd && e >= 8 && e <= 15) begin
        chk({tag, " R4 oe"}, {7'd0, sd_oe}, 8'd1);
        chk({tag, " R3 bit"}, {7'd0, sd_out}, {7'd0, exp[15-e]});
      end else begin
        chk({tag, " R4/R9 oe"}, {7'd0, sd_oe}, 8'd0);
      end
    end
    if (!rd && nbits == 16 && a[1:0] == 0 && a / 4 < NR && a != 0) model[a/4] = d;
    @(negedge sclk); cs_n = 1;
    idle(2, {tag, " R4 idle"});
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    xfer(1, a, 8'h00, 16, 0, tag);
  endtask

  initial begin
    #(P * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 0;
    repeat (3) @(posedge sclk);
    #(P/4);
    chk("R4 reset oe", {7'd0, sd_oe}, 8'd0);
    @(negedge sclk); rst_n = 1;
    // R8 and R5: reset contents and version
    for (int i = 0; i < NR; i++) rd_chk(8'(4*i), "R8/R5/R1 reset read");
    // R2: write each register, read back
    for (int i = 1; i < NR; i++) xfer(0, 8'(4*i), 8'((i*37 + 5) & 8'hFF), 16, 0, "R2 write");
    for (int i = 0; i < NR; i++) rd_chk(8'(4*i), "R2/R1 readback");
    // R5: register 0 read-only
    xfer(0, 8'h00, 8'hFF, 16, 0, "R5 write reg0");
    rd_chk(8'h00, "R5 version");
    // R6: invalid addresses
    xfer(0, 8'h45, 8'hA5, 16, 0, "R6 misaligned write");
    xfer(0, 8'h48, 8'h5A, 16, 0, "R6 high write");
    xfer(0, 8'hFC, 8'h33, 16, 0, "R6 top write");
    rd_chk(8'h45, "R6 misaligned read");
    rd_chk(8'h48, "R6 high read");
    rd_chk(8'h44, "R6 neighbour 44");
    rd_chk(8'h04, "R6 neighbour 04");
    // R7: abort mid-write and mid-read
    xfer(0, 8'h10, 8'hEE, 12, 0, "R7 abort write");
    rd_chk(8'h10, "R7 after abort");
    xfer(0, 8'h14, 8'h81, 5, 0, "R7 abort in addr");
    xfer(1, 8'h14, 8'h00, 11, 0, "R7 abort read");
    rd_chk(8'h14, "R7 restart read");
    // R9: overrun clocks after a write
    xfer(0, 8'h08, 8'hC3, 16, 9, "R9 overrun write");
    rd_chk(8'h08, "R9 readback");
    xfer(1, 8'h08, 8'h00, 16, 6, "R9 overrun read");
    // R10: reads leave contents unchanged
    rd_chk(8'h20, "R10 read one");
    rd_chk(8'h20, "R10 read two");
    xfer(0, 8'h20, 8'h00, 16, 0, "R2 write zero");
    xfer(0, 8'h44, 8'hFF, 16, 0, "R2 write ones");
    rd_chk(8'h20, "R2 zero back");
    rd_chk(8'h44, "R2 ones back");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule